// File: doc/BRIEF.md
# Peripheral Clock Gate Controller

This block is an APB slave that owns one clock-enable bit for each of up to eight peripherals. It also sits in the bus path in front of them. Each enable bit feeds a short synchronising pipeline whose last stage is the clock-enable strobe handed to that peripheral's glitch-free clock cell. Every bus access that falls into a peripheral's 256-byte window passes through the controller. If that peripheral's strobe is high, the access is forwarded. If the strobe is low, the controller answers the access itself and the peripheral never sees it.

How a gated access is answered is fixed per instance by the `POLICY` parameter. With `2'b00` reads return zero. With `2'b01` reads return the last data the peripheral supplied on a forwarded read. With `2'b10` every gated access, read or write, gets an error response. Under the first two policies a gated write completes quietly and its data is dropped. A read of the enable register is held until the strobe outputs agree with the register, so software can use that read as a barrier before it first touches a newly enabled peripheral.

The bus controller is a four-state machine. `ST_IDLE` decodes the setup phase. It moves to `ST_REG` for the enable register (PADDR[11]=1), to `ST_FWD` when the target window's strobe is high, and to `ST_GATED` otherwise. `ST_FWD` returns to `ST_IDLE` when the forwarded peripheral raises its ready. `ST_GATED` returns after its single access cycle. `ST_REG` returns after its access cycle for writes, and for reads once no enable change is still in flight. Peripherals share PADDR, PWRITE and PWDATA from the fabric; only their select and enable come from this block.

Top module: `periph_clk_gate`

## Requirements
- R1: After reset every clock-enable strobe is 0 and the enable register reads 0.
- R2: Under policies 00 and 01 a write to a gated peripheral completes with PREADY high in its first access cycle and PSLVERR low, and the peripheral's stored state is unchanged when it is later enabled and read.
- R3: Under policy 00 a read of a gated peripheral returns 0x00000000 with PSLVERR low and no wait state.
- R4: Under policy 01 a read of a gated peripheral returns the data of that peripheral's most recent forwarded read, or 0 if it has never been read.
- R5: Under policy 10 every access, read or write, to a gated peripheral completes in its first access cycle with PSLVERR high and read data 0.
- R6: A read of the enable register holds PREADY low while any enable change is still in the strobe pipeline. It completes with the strobes equal to the register. With the default 2-stage pipeline, a read directly after an enable write has exactly one wait state.
- R7: The select and enable of a peripheral whose strobe is low are never asserted.
- R8: With PADDR[11]=1, PADDR[3:2] picks the register view. 0 loads the enable bits, 1 sets the written ones bits, 2 clears the written ones bits, and bit i controls peripheral i. Views 0 to 2 read back the enable bits. View 3 reads 0 and ignores writes.
- R9: An enable change reaches the strobe output SYNC_STAGES clock edges after the edge that completes the write.
- R10: With PADDR[11]=0, PADDR[10:8] selects a peripheral. An access to a clocked peripheral is forwarded with its select in setup and access phases, and that peripheral's PRDATA, PREADY and PSLVERR are returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_psel | input | 1 | Slave select from the bus |
| s_penable | input | 1 | Access phase marker |
| s_pwrite | input | 1 | 1 = write |
| s_paddr | input | 12 | Byte address |
| s_pwdata | input | DATA_W | Write data |
| s_prdata | output | DATA_W | Read data |
| s_pready | output | 1 | Transfer ready |
| s_pslverr | output | 1 | Error response |
| m_psel | output | NUM_PERIPH | Per-peripheral select |
| m_penable | output | NUM_PERIPH | Per-peripheral access phase |
| m_prdata | input | NUM_PERIPH*DATA_W | Peripheral read data, peripheral i at bits [i*DATA_W +: DATA_W] |
| m_pready | input | NUM_PERIPH | Peripheral ready |
| m_pslverr | input | NUM_PERIPH | Peripheral error |
| clk_en | output | NUM_PERIPH | Clock-enable strobe per peripheral |

## Verification
A stale or wrong enable bit shows up at `clk_en` within SYNC_STAGES edges. It also appears on the very next register read-back, which returns the wrong bits or waits for the wrong number of cycles. A state machine that mis-decodes the gate shows up in the same transfer: a select toggles toward an unclocked peripheral, or a gated access returns forwarded data or the wrong error flag. A corrupted stale-data slot stays hidden until the next gated read of that peripheral under the stale policy, and that read then returns the wrong word.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    localparam int APB_AW = 12;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FWD,
        ST_GATED,
        ST_REG
    } bus_state_e;

    typedef enum logic [1:0] {
        OP_LOAD,
        OP_SET,
        OP_CLR,
        OP_NONE
    } gate_op_e;

    localparam logic [1:0] POL_ZERO  = 2'b00;
    localparam logic [1:0] POL_STALE = 2'b01;
    localparam logic [1:0] POL_ERROR = 2'b10;

endpackage

// File: rtl/pcg_gate_bank.sv
module pcg_gate_bank
    import pcg_pkg::*;
#(
    parameter int N           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  gate_op_e     wr_op,
    input  logic [N-1:0] wr_bits,
    output logic [N-1:0] en_q,
    output logic [N-1:0] clk_en,
    output logic         pending
);

    logic [N-1:0] en_d;
    logic [N-1:0] stage_diff;

    always_comb begin
        unique case (wr_op)
            OP_LOAD: en_d = wr_bits;
            OP_SET:  en_d = en_q | wr_bits;
            OP_CLR:  en_d = en_q & ~wr_bits;
            default: en_d = en_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= en_d;
        end
    end

    // One synchronising chain per enable bit; the last stage is the strobe.
    for (genvar g = 0; g < N; g++) begin : g_chain
        logic [SYNC_STAGES-1:0] pipe;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= '0;
            end else begin
                pipe[0] <= en_q[g];
                for (int s = 1; s < SYNC_STAGES; s++) begin
                    pipe[s] <= pipe[s-1];
                end
            end
        end

        assign clk_en[g]     = pipe[SYNC_STAGES-1];
        assign stage_diff[g] = (pipe != {SYNC_STAGES{en_q[g]}});
    end

    assign pending = |stage_diff;

    // R1: reset leaves every strobe and register bit clear
    p_reset_gated_r1: assert property (@(posedge clk)
        !rst_n |=> (clk_en == '0 && en_q == '0));

    // R9: a real enable change is always in flight on the next cycle
    p_change_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && en_d != en_q) |=> pending);

    // R9: with nothing in flight and no write, the strobes hold
    p_settled_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !pending) |=> ($stable(clk_en) && !pending));

endmodule

// File: rtl/pcg_stale_store.sv
module pcg_stale_store #(
    parameter int N     = 8,
    parameter int DW    = 32,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic [DW-1:0]    cap_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);

    logic [DW-1:0] slot [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                slot[i] <= '0;
            end
        end else if (cap_en && int'(cap_idx) < N) begin
            slot[cap_idx] <= cap_data;
        end
    end

    assign rd_data = (int'(rd_idx) < N) ? slot[rd_idx] : '0;

endmodule

// File: rtl/pcg_bus_fsm.sv
module pcg_bus_fsm
    import pcg_pkg::*;
#(
    parameter int         N      = 8,
    parameter int         DW     = 32,
    parameter logic [1:0] POLICY = POL_ZERO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_psel,
    input  logic              s_penable,
    input  logic              s_pwrite,
    input  logic [APB_AW-1:0] s_paddr,
    input  logic [DW-1:0]     s_pwdata,
    output logic [DW-1:0]     s_prdata,
    output logic              s_pready,
    output logic              s_pslverr,
    output logic [N-1:0]      m_psel,
    output logic [N-1:0]      m_penable,
    input  logic [N*DW-1:0]   m_prdata,
    input  logic [N-1:0]      m_pready,
    input  logic [N-1:0]      m_pslverr,
    input  logic [N-1:0]      clk_en,
    input  logic [N-1:0]      en_q,
    input  logic              pending,
    output logic              gate_wr,
    output gate_op_e          gate_op,
    output logic [N-1:0]      gate_bits,
    output logic              stale_cap,
    output logic [2:0]        stale_idx,
    input  logic [DW-1:0]     stale_rdata
);

    localparam int MAXP    = 8;
    localparam int REG_SEL = 11;

    bus_state_e state_q, state_d;
    logic [2:0] idx_q;
    logic       write_q;
    logic [1:0] view_q;

    logic            setup;
    logic            is_reg;
    logic [2:0]      dec_idx;
    logic            dec_live;
    logic [MAXP-1:0] clk_en_pad, pready_pad, pslverr_pad, psel_pad, penable_pad;
    logic [DW-1:0]   fwd_data;
    logic            unused_bits;

    assign unused_bits = ^{s_paddr[7:4], s_paddr[1:0], s_pwdata[DW-1:N]};

    always_comb begin
        clk_en_pad           = '0;
        clk_en_pad[N-1:0]    = clk_en;
        pready_pad           = '0;
        pready_pad[N-1:0]    = m_pready;
        pslverr_pad          = '0;
        pslverr_pad[N-1:0]   = m_pslverr;
    end

    assign setup    = s_psel && !s_penable;
    assign is_reg   = s_paddr[REG_SEL];
    assign dec_idx  = s_paddr[10:8];
    assign dec_live = (int'(dec_idx) < N) && clk_en_pad[dec_idx];
    assign fwd_data = (int'(idx_q) < N) ? m_prdata[int'(idx_q)*DW +: DW] : '0;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (setup) begin
                    if (is_reg)        state_d = ST_REG;
                    else if (dec_live) state_d = ST_FWD;
                    else               state_d = ST_GATED;
                end
            end
            ST_FWD: begin
                if (s_penable && pready_pad[idx_q]) state_d = ST_IDLE;
            end
            ST_GATED: begin
                if (s_penable) state_d = ST_IDLE;
            end
            ST_REG: begin
                if (s_penable && (write_q || !pending)) state_d = ST_IDLE;
            end
        endcase
    end

    // State register and transfer context captured in the setup phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            write_q <= 1'b0;
            view_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && setup) begin
                idx_q   <= dec_idx;
                write_q <= s_pwrite;
                view_q  <= s_paddr[3:2];
            end
        end
    end

    // Outputs
    always_comb begin
        psel_pad    = '0;
        penable_pad = '0;
        s_pready    = 1'b0;
        s_pslverr   = 1'b0;
        s_prdata    = '0;
        gate_wr     = 1'b0;
        stale_cap   = 1'b0;
        unique case (view_q)
            2'd0:    gate_op = OP_LOAD;
            2'd1:    gate_op = OP_SET;
            2'd2:    gate_op = OP_CLR;
            default: gate_op = OP_NONE;
        endcase
        unique case (state_q)
            ST_IDLE: begin
                if (setup && !is_reg && dec_live) psel_pad[dec_idx] = 1'b1;
            end
            ST_FWD: begin
                psel_pad[idx_q]    = 1'b1;
                penable_pad[idx_q] = s_penable;
                s_pready           = pready_pad[idx_q];
                s_pslverr          = pslverr_pad[idx_q];
                s_prdata           = write_q ? '0 : fwd_data;
                stale_cap          = s_penable && pready_pad[idx_q] && !write_q;
            end
            ST_GATED: begin
                s_pready  = 1'b1;
                s_pslverr = (POLICY == POL_ERROR);
                s_prdata  = (!write_q && POLICY == POL_STALE) ? stale_rdata : '0;
            end
            ST_REG: begin
                s_pready = write_q || !pending;
                s_prdata = (!write_q && view_q != 2'd3) ? {{(DW-N){1'b0}}, en_q} : '0;
                gate_wr  = s_penable && write_q && view_q != 2'd3;
            end
        endcase
    end

    assign m_psel    = psel_pad[N-1:0];
    assign m_penable = penable_pad[N-1:0];
    assign gate_bits = s_pwdata[N-1:0];
    assign stale_idx = idx_q;

    // R7: an unclocked peripheral never sees select or enable
    p_gated_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_psel | m_penable) & ~clk_en) == '0);

    // R10: at most one peripheral is addressed at a time
    p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_psel));

    // R10: a stalled forwarded access keeps its target selected
    p_fwd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FWD && s_penable && !s_pready) |=> $stable(m_psel));

    // R6: a completing read-back sees strobes equal to the register
    p_barrier_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REG && !write_q && s_penable && s_pready) |-> (clk_en == en_q));

    // R2: quiet policies never raise an error on a gated access
    p_quiet_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (POLICY != POL_ERROR && state_q == ST_GATED) |-> !s_pslverr);

    // R5: the strict policy answers a gated access at once with an error
    p_strict_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (POLICY == POL_ERROR && state_q == ST_GATED && s_penable) |-> (s_pready && s_pslverr && m_psel == '0));

endmodule

// File: rtl/periph_clk_gate.sv
module periph_clk_gate
    import pcg_pkg::*;
#(
    parameter int         NUM_PERIPH  = 8,
    parameter int         DATA_W      = 32,
    parameter int         SYNC_STAGES = 2,
    parameter logic [1:0] POLICY      = POL_ZERO
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         s_psel,
    input  logic                         s_penable,
    input  logic                         s_pwrite,
    input  logic [11:0]                  s_paddr,
    input  logic [DATA_W-1:0]            s_pwdata,
    output logic [DATA_W-1:0]            s_prdata,
    output logic                         s_pready,
    output logic                         s_pslverr,
    output logic [NUM_PERIPH-1:0]        m_psel,
    output logic [NUM_PERIPH-1:0]        m_penable,
    input  logic [NUM_PERIPH*DATA_W-1:0] m_prdata,
    input  logic [NUM_PERIPH-1:0]        m_pready,
    input  logic [NUM_PERIPH-1:0]        m_pslverr,
    output logic [NUM_PERIPH-1:0]        clk_en
);

    localparam int IDX_W = 3;

    logic [NUM_PERIPH-1:0] en_q;
    logic [NUM_PERIPH-1:0] gate_bits;
    logic                  pending;
    logic                  gate_wr;
    gate_op_e              gate_op;
    logic                  stale_cap;
    logic [IDX_W-1:0]      stale_idx;
    logic [DATA_W-1:0]     stale_rdata;

    pcg_gate_bank #(
        .N           (NUM_PERIPH),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_gates (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (gate_wr),
        .wr_op   (gate_op),
        .wr_bits (gate_bits),
        .en_q    (en_q),
        .clk_en  (clk_en),
        .pending (pending)
    );

    if (POLICY == POL_STALE) begin : g_stale
        pcg_stale_store #(
            .N     (NUM_PERIPH),
            .DW    (DATA_W),
            .IDX_W (IDX_W)
        ) u_stale (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_en   (stale_cap),
            .cap_idx  (stale_idx),
            .cap_data (s_prdata),
            .rd_idx   (stale_idx),
            .rd_data  (stale_rdata)
        );
    end else begin : g_no_stale
        assign stale_rdata = '0;
    end

    pcg_bus_fsm #(
        .N      (NUM_PERIPH),
        .DW     (DATA_W),
        .POLICY (POLICY)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .s_psel      (s_psel),
        .s_penable   (s_penable),
        .s_pwrite    (s_pwrite),
        .s_paddr     (s_paddr),
        .s_pwdata    (s_pwdata),
        .s_prdata    (s_prdata),
        .s_pready    (s_pready),
        .s_pslverr   (s_pslverr),
        .m_psel      (m_psel),
        .m_penable   (m_penable),
        .m_prdata    (m_prdata),
        .m_pready    (m_pready),
        .m_pslverr   (m_pslverr),
        .clk_en      (clk_en),
        .en_q        (en_q),
        .pending     (pending),
        .gate_wr     (gate_wr),
        .gate_op     (gate_op),
        .gate_bits   (gate_bits),
        .stale_cap   (stale_cap),
        .stale_idx   (stale_idx),
        .stale_rdata (stale_rdata)
    );

endmodule

// File: tb/periph_clk_gate_tb.sv
module pcg_tb_periph (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [7:0]   psel,
    input  logic [7:0]   penable,
    input  logic [7:0]   clk_en,
    input  logic         pwrite,
    input  logic [31:0]  pwdata,
    output logic [255:0] prdata,
    output logic [7:0]   pready,
    output logic [7:0]   pslverr,
    output int           viol
);
    logic [31:0] mem [8];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) mem[i] <= '0;
            viol <= 0;
        end else begin
            for (int i = 0; i < 8; i++) begin
                if (psel[i] && penable[i] && pwrite && clk_en[i]) mem[i] <= pwdata;
            end
            viol <= viol + $countones((psel | penable) & ~clk_en);
        end
    end

    for (genvar g = 0; g < 8; g++) begin : g_rd
        assign prdata[g*32 +: 32] = mem[g];
    end
    assign pready  = '1;
    assign pslverr = '0;
endmodule

module periph_clk_gate_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;

    logic [31:0]  rdata  [3];
    logic         rdy    [3];
    logic         err    [3];
    logic [7:0]   msel   [3];
    logic [7:0]   men    [3];
    logic [7:0]   cen    [3];
    logic [255:0] mrd    [3];
    logic [7:0]   mrdy   [3];
    logic [7:0]   merr   [3];
    int           viol   [3];

    periph_clk_gate #(.POLICY(2'b00)) u_dut (
        .clk(clk), .rst_n(rst_n), .s_psel(psel), .s_penable(penable), .s_pwrite(pwrite),
        .s_paddr(paddr), .s_pwdata(pwdata), .s_prdata(rdata[0]), .s_pready(rdy[0]),
        .s_pslverr(err[0]), .m_psel(msel[0]), .m_penable(men[0]), .m_prdata(mrd[0]),
        .m_pready(mrdy[0]), .m_pslverr(merr[0]), .clk_en(cen[0]));
    periph_clk_gate #(.POLICY(2'b01)) u_dut_stale (
        .clk(clk), .rst_n(rst_n), .s_psel(psel), .s_penable(penable), .s_pwrite(pwrite),
        .s_paddr(paddr), .s_pwdata(pwdata), .s_prdata(rdata[1]), .s_pready(rdy[1]),
        .s_pslverr(err[1]), .m_psel(msel[1]), .m_penable(men[1]), .m_prdata(mrd[1]),
        .m_pready(mrdy[1]), .m_pslverr(merr[1]), .clk_en(cen[1]));
    periph_clk_gate #(.POLICY(2'b10)) u_dut_err (
        .clk(clk), .rst_n(rst_n), .s_psel(psel), .s_penable(penable), .s_pwrite(pwrite),
        .s_paddr(paddr), .s_pwdata(pwdata), .s_prdata(rdata[2]), .s_pready(rdy[2]),
        .s_pslverr(err[2]), .m_psel(msel[2]), .m_penable(men[2]), .m_prdata(mrd[2]),
        .m_pready(mrdy[2]), .m_pslverr(merr[2]), .clk_en(cen[2]));

    for (genvar k = 0; k < 3; k++) begin : g_pm
        pcg_tb_periph u_pm (
            .clk(clk), .rst_n(rst_n), .psel(msel[k]), .penable(men[k]), .clk_en(cen[k]),
            .pwrite(pwrite), .pwdata(pwdata), .prdata(mrd[k]), .pready(mrdy[k]),
            .pslverr(merr[k]), .viol(viol[k]));
    end

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] c_rd [3];
    logic        c_err [3];
    logic [7:0]  c_en [3];
    int          c_waits;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One APB transfer; returns just after the completing clock edge.
    task automatic apb(input logic wr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        c_waits = 0;
        #1;
        while (!rdy[0] && c_waits < 20) begin
            c_waits++;
            @(negedge clk);
            #1;
        end
        for (int k = 0; k < 3; k++) begin
            c_rd[k] = rdata[k]; c_err[k] = err[k]; c_en[k] = cen[k];
        end
        @(posedge clk);
    endtask

    task automatic bus_idle();
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        for (int k = 0; k < 3; k++) chk("R1 strobes after reset", 32'(cen[k]), 32'h0);
        apb(1'b0, 12'h800, '0);
        chk("R1 enable register after reset", c_rd[0], 32'h0);
        chk("R1 read-back no wait", c_waits, 0);
        bus_idle();
    endtask

    task automatic t_gating();
        apb(1'b1, 12'h800, 32'h04);
        apb(1'b0, 12'h800, '0);
        chk("R8 load view", c_rd[0], 32'h04);
        apb(1'b1, 12'h200, 32'hA5A5_0002);
        chk("R10 forwarded write no error", 32'(c_err[0]), 0);
        apb(1'b0, 12'h200, '0);
        for (int k = 0; k < 3; k++) chk("R10 forwarded read data", c_rd[k], 32'hA5A5_0002);
        apb(1'b1, 12'h808, 32'h04);
        apb(1'b0, 12'h800, '0);
        chk("R8 clear view", c_rd[0], 32'h0);
        apb(1'b1, 12'h200, 32'h1111_1111);
        chk("R2 gated write no wait", c_waits, 0);
        chk("R2 gated write no error (zero)", 32'(c_err[0]), 0);
        chk("R2 gated write no error (stale)", 32'(c_err[1]), 0);
        chk("R5 gated write error", 32'(c_err[2]), 1);
        apb(1'b0, 12'h200, '0);
        chk("R3 gated read no wait", c_waits, 0);
        chk("R3 gated read zero", c_rd[0], 32'h0);
        chk("R3 gated read no error", 32'(c_err[0]), 0);
        chk("R4 gated read stale", c_rd[1], 32'hA5A5_0002);
        chk("R4 stale read no error", 32'(c_err[1]), 0);
        chk("R5 gated read error", 32'(c_err[2]), 1);
        chk("R5 gated read data zero", c_rd[2], 32'h0);
        apb(1'b0, 12'h300, '0);
        chk("R4 never-read stale is zero", c_rd[1], 32'h0);
        apb(1'b1, 12'h804, 32'h04);
        apb(1'b0, 12'h800, '0);
        chk("R8 set view", c_rd[0], 32'h04);
        apb(1'b0, 12'h200, '0);
        for (int k = 0; k < 3; k++) chk("R2 gated write dropped", c_rd[k], 32'hA5A5_0002);
        bus_idle();
    endtask

    task automatic t_barrier();
        apb(1'b1, 12'h800, 32'h3C);
        apb(1'b0, 12'h800, '0);
        chk("R6 one wait state after write", c_waits, 1);
        chk("R6 read-back value", c_rd[0], 32'h3C);
        chk("R6 strobes match at completion", 32'(c_en[0]), 32'h3C);
        apb(1'b0, 12'h800, '0);
        chk("R6 no wait when settled", c_waits, 0);
        bus_idle();
    endtask

    task automatic t_alias();
        apb(1'b1, 12'h800, 32'h0F);
        apb(1'b1, 12'h804, 32'h30);
        apb(1'b0, 12'h804, '0);
        chk("R8 set merges", c_rd[0], 32'h3F);
        apb(1'b1, 12'h808, 32'h05);
        apb(1'b0, 12'h808, '0);
        chk("R8 clear removes", c_rd[0], 32'h3A);
        chk("R8 strobes follow", 32'(c_en[0]), 32'h3A);
        apb(1'b1, 12'h80C, 32'hFF);
        apb(1'b0, 12'h80C, '0);
        chk("R8 reserved view reads zero", c_rd[0], 32'h0);
        apb(1'b0, 12'h800, '0);
        chk("R8 reserved write ignored", c_rd[0], 32'h3A);
        bus_idle();
    endtask

    task automatic t_lag();
        apb(1'b1, 12'h800, 32'hBA);
        bus_idle();
        chk("R9 unchanged after 0 edges", 32'(cen[0]), 32'h3A);
        @(negedge clk);
        chk("R9 unchanged after 1 edge", 32'(cen[0]), 32'h3A);
        @(negedge clk);
        chk("R9 changed after 2 edges", 32'(cen[0]), 32'hBA);
    endtask

    task automatic t_forward_top();
        apb(1'b1, 12'h7F0, 32'hC0DE_0007);
        apb(1'b0, 12'h700, '0);
        chk("R10 window 7 data", c_rd[0], 32'hC0DE_0007);
        chk("R10 window 7 no error", 32'(c_err[2]), 0);
        apb(1'b0, 12'h300, '0);
        chk("R10 window 3 returns own data", c_rd[0], 32'h0);
        bus_idle();
        for (int k = 0; k < 3; k++) chk("R7 no access to gated peripheral", viol[k], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gating();
        t_barrier();
        t_alias();
        t_lag();
        t_forward_top();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule